// File: doc/BRIEF.md
# Reloadable Modulus Down-Counter

A 16-bit down-counter paced by a selectable prescaler. The prescaler counts pulses on a clock-enable input and emits one terminal tick every 1, 4, 8 or 16 pulses. On each terminal tick, an enabled counter steps down by one. In single-run mode the count stops at zero. In reload mode, the terminal tick that would end the run instead restores the value last written by software, so the counter produces a steady period.

Software reaches the block through a small word-wide register bus with three registers: control, count and flag. A write to the count register stores the value in a load register. A read-select control bit chooses whether reads of the count register return the live count or the stored load value. A write-one strobe in the control register copies the load value into the counter at once and restarts the prescaler. Each finished run raises a sticky underflow flag, which software clears by writing one to it.

Top module: `reload_downcounter`

## Requirements
- R1: After reset, the control register reads 0x0000, the count register reads 0x00FF, the flag register reads 0 and `uf_flag` is 0.
- R2: While the enable bit (control bit 0) is 0, the counter is held at 0x00FF. A count-register write then updates only the load register. The prescaler is held at its start.
- R3: Control bits 5:4 set the prescaler ratio: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 16 `tick_in` pulses per terminal tick. An enabled counter decrements once per terminal tick.
- R4: With the mode bit (control bit 1) at 0, the terminal tick at count 1 takes the counter to 0x0000. The counter then holds there.
- R5: With the mode bit at 1, a terminal tick at count 1 or 0 loads the counter from the load register, and counting continues.
- R6: While enabled, a count-register write (address 1) loads both the load register and the counter, and restarts the prescaler.
- R7: With the read-select bit (control bit 2) at 0, reads at address 1 return the live count. At 1, they return the load register.
- R8: Writing control bit 3 as 1 while already enabled copies the load register into the counter and restarts the prescaler. Writing it as 0 has no effect. It always reads as 0.
- R9: Any terminal tick taken at count 1 sets the underflow flag (address 2, bit 0, also on `uf_flag`). Writing 1 to that bit clears it, writing 0 leaves it alone, and a set in the same cycle wins.
- R10: Address 0 reads back the control fields at their write positions. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | Clock-enable pulse counted by the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 count, 2 flag) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| uf_flag | output | 1 | Sticky underflow flag |

## Verification
The counting path is driven from a table of runs, one for each prescaler ratio, in both modes and with tick counts that stop short of a run's end, land exactly on it or go past it. A wrong ratio shifts the final count, and a missing reload or a missing hold at zero shows up as a different count after the same number of ticks. Directed runs use a force strobe placed mid-prescale to show that the prescaler restarted, not just that the counter was reloaded. The read-select runs make live count and load value differ before reading, so that a swapped mux cannot pass.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_COUNT = 2'd1,
    ADDR_FLAG  = 2'd2,
    ADDR_NONE  = 2'd3
  } rdc_addr_e;

  localparam int CB_EN    = 0;
  localparam int CB_MODE  = 1;
  localparam int CB_RSEL  = 2;
  localparam int CB_FORCE = 3;
  localparam int CB_PS    = 4;
endpackage

// File: rtl/rdc_prescaler.sv
module rdc_prescaler #(
  parameter int PSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           tick_in,
  input  logic [PSW-1:0] sel,
  output logic           term
);
  localparam int PCW = 1 << PSW;

  logic [PCW-1:0] pcnt_q;

  // last phase value for a select code: 0 -> 0, s -> 2^(s+1)-1
  function automatic logic [PCW-1:0] last_phase(input logic [PSW-1:0] s);
    logic [PCW:0] tmp;
    if (s == '0) return '0;
    tmp = ({{PCW{1'b0}}, 1'b1} << (int'(s) + 1)) - 1'b1;
    return tmp[PCW-1:0];
  endfunction

  assign term = tick_in && (pcnt_q == last_phase(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (restart) pcnt_q <= '0;
    else if (tick_in) pcnt_q <= term ? '0 : pcnt_q + 1'b1;
  end
endmodule

// File: rtl/rdc_core.sv
module rdc_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          mode,
  input  logic          tick_term,
  input  logic          cnt_wr,
  input  logic [CW-1:0] wdata,
  input  logic          force_ld,
  input  logic          flag_clr,
  output logic [CW-1:0] count_q,
  output logic [CW-1:0] load_q,
  output logic          uf_evt,
  output logic          flag_q
);
  localparam logic [CW-1:0] IDLE_VAL = CW'(255);
  localparam logic [CW-1:0] ONE      = CW'(1);

  // value after one terminal tick
  function automatic logic [CW-1:0] step(input logic [CW-1:0] c,
                                         input logic [CW-1:0] ld,
                                         input logic          rl);
    if (c > ONE) return c - ONE;
    return rl ? ld : '0;
  endfunction

  assign uf_evt = en && !cnt_wr && !force_ld && tick_term && (count_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= IDLE_VAL;
      load_q  <= '0;
    end else begin
      if (cnt_wr) load_q <= wdata;
      if (!en)            count_q <= IDLE_VAL;
      else if (cnt_wr)    count_q <= wdata;
      else if (force_ld)  count_q <= load_q;
      else if (tick_term) count_q <= step(count_q, load_q, mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (uf_evt)   flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end
endmodule

// File: rtl/reload_downcounter.sv
module reload_downcounter #(
  parameter int CW  = 16,
  parameter int PSW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_in,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          uf_flag
);
  import rdc_pkg::*;

  logic           en_q, mode_q, rsel_q;
  logic [PSW-1:0] ps_q;
  logic           ctrl_wr, cnt_wr, flag_clr, force_ld, ps_restart, tick_term;
  logic [CW-1:0]  count_q, load_q;
  logic           uf_evt, flag_q;
  logic [CW-1:0]  ctrl_rd;

  assign ctrl_wr    = bus_wr && (bus_addr == ADDR_CTRL);
  assign cnt_wr     = bus_wr && (bus_addr == ADDR_COUNT);
  assign flag_clr   = bus_wr && (bus_addr == ADDR_FLAG) && bus_wdata[0];
  assign force_ld   = ctrl_wr && bus_wdata[CB_FORCE] && en_q;
  assign ps_restart = !en_q || cnt_wr || force_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      rsel_q <= 1'b0;
      ps_q   <= '0;
    end else if (ctrl_wr) begin
      en_q   <= bus_wdata[CB_EN];
      mode_q <= bus_wdata[CB_MODE];
      rsel_q <= bus_wdata[CB_RSEL];
      ps_q   <= bus_wdata[CB_PS +: PSW];
    end
  end

  rdc_prescaler #(.PSW(PSW)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ps_restart),
    .tick_in (tick_in),
    .sel     (ps_q),
    .term    (tick_term)
  );

  rdc_core #(.CW(CW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .mode      (mode_q),
    .tick_term (tick_term),
    .cnt_wr    (cnt_wr && en_q ? 1'b1 : cnt_wr),
    .wdata     (bus_wdata),
    .force_ld  (force_ld),
    .flag_clr  (flag_clr),
    .count_q   (count_q),
    .load_q    (load_q),
    .uf_evt    (uf_evt),
    .flag_q    (flag_q)
  );

  always_comb begin
    ctrl_rd                  = '0;
    ctrl_rd[CB_EN]           = en_q;
    ctrl_rd[CB_MODE]         = mode_q;
    ctrl_rd[CB_RSEL]         = rsel_q;
    ctrl_rd[CB_PS +: PSW]    = ps_q;
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL:  bus_rdata = ctrl_rd;
      ADDR_COUNT: bus_rdata = rsel_q ? load_q : count_q;
      ADDR_FLAG:  bus_rdata = {{(CW-1){1'b0}}, flag_q};
      default:    bus_rdata = '0;
    endcase
  end

  assign uf_flag = flag_q;
endmodule

// File: rtl/rdc_checker.sv
module rdc_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_q,
  input logic          mode_q,
  input logic          tick_term,
  input logic          cnt_wr,
  input logic          force_ld,
  input logic          uf_evt,
  input logic [CW-1:0] count_q,
  input logic [CW-1:0] load_q,
  input logic [1:0]    bus_addr,
  input logic [CW-1:0] bus_rdata,
  input logic          uf_flag
);
  localparam logic [CW-1:0] IDLE_VAL = CW'(255);
  localparam logic [CW-1:0] ONE      = CW'(1);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> count_q == IDLE_VAL);

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && tick_term && count_q > ONE && !cnt_wr && !force_ld
    |=> count_q == $past(count_q) - ONE);

  assert_zero_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && !mode_q && count_q == '0 && !cnt_wr && !force_ld |=> count_q == '0);

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && mode_q && tick_term && count_q <= ONE && !cnt_wr && !force_ld
    |=> count_q == $past(load_q));

  assert_force_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_ld |=> count_q == $past(load_q));

  assert_strobe_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 2'd0 |-> !bus_rdata[3]);

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> uf_flag);
endmodule

bind reload_downcounter rdc_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_q      (en_q),
  .mode_q    (mode_q),
  .tick_term (tick_term),
  .cnt_wr    (cnt_wr),
  .force_ld  (force_ld),
  .uf_evt    (uf_evt),
  .count_q   (count_q),
  .load_q    (load_q),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .uf_flag   (uf_flag)
);

// File: tb/reload_downcounter_tb.sv
module reload_downcounter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        uf_flag;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  reload_downcounter u_dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .uf_flag(uf_flag)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        mode;
    logic [7:0]  ticks;
    logic [15:0] start;
    logic [15:0] expc;
    logic        expf;
  } vec_t;

  // ratio, mode, ticks, start -> expected count and flag
  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 8'd3,  16'd10, 16'd7, 1'b0},
    '{2'd1, 1'b0, 8'd9,  16'd10, 16'd8, 1'b0},
    '{2'd2, 1'b0, 8'd24, 16'd5,  16'd2, 1'b0},
    '{2'd3, 1'b0, 8'd47, 16'd3,  16'd1, 1'b0},
    '{2'd0, 1'b0, 8'd10, 16'd4,  16'd0, 1'b1},
    '{2'd0, 1'b1, 8'd5,  16'd5,  16'd5, 1'b1},
    '{2'd0, 1'b1, 8'd7,  16'd5,  16'd3, 1'b1},
    '{2'd1, 1'b1, 8'd20, 16'd3,  16'd1, 1'b1}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_in = 1'b1;
    repeat (n) @(negedge clk);
    tick_in = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 16'h0000);
    rd(2'd1, d); check("R1 count", d, 16'h00FF);
    rd(2'd2, d); check("R1 flag reg", d, 16'h0000);
    check("R1 uf_flag", {15'd0, uf_flag}, 16'h0000);

    // R3 R4 R5 R9 table of runs
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, 16'h0000);
      wr(2'd2, 16'h0001);
      wr(2'd0, {10'd0, VECS[i].sel, 2'b00, VECS[i].mode, 1'b1});
      wr(2'd1, VECS[i].start);
      ticks(int'(VECS[i].ticks));
      rd(2'd1, d);
      check($sformatf("R3/R4/R5 vec%0d count", i), d, VECS[i].expc);
      check($sformatf("R9 vec%0d flag", i), {15'd0, uf_flag}, {15'd0, VECS[i].expf});
    end

    // R9 flag: write 0 keeps it, write 1 clears it (flag set by last run)
    wr(2'd2, 16'h0000);
    rd(2'd2, d); check("R9 write0 keeps flag", d, 16'h0001);
    wr(2'd2, 16'h0001);
    rd(2'd2, d); check("R9 write1 clears flag", d, 16'h0000);

    // R2 disabled: held at 0x00FF, write updates only load
    wr(2'd0, 16'h0004);
    wr(2'd1, 16'h0042);
    rd(2'd1, d); check("R2 load via rsel", d, 16'h0042);
    wr(2'd0, 16'h0000);
    ticks(5);
    rd(2'd1, d); check("R2 count held", d, 16'h00FF);

    // R7 read select, R6 count write while enabled
    wr(2'd0, 16'h0005);
    wr(2'd1, 16'h1234);
    ticks(4);
    rd(2'd1, d); check("R7 rsel=1 load", d, 16'h1234);
    wr(2'd0, 16'h0001);
    rd(2'd1, d); check("R6/R7 rsel=0 live", d, 16'h1230);

    // R8 force load and prescaler restart, ratio 4
    wr(2'd0, 16'h0011);
    wr(2'd1, 16'd20);
    ticks(6);
    rd(2'd1, d); check("R3 one terminal in 6", d, 16'd19);
    wr(2'd0, 16'h0011);
    rd(2'd1, d); check("R8 force bit 0 no effect", d, 16'd19);
    wr(2'd0, 16'h0019);
    rd(2'd1, d); check("R8 force copies load", d, 16'd20);
    rd(2'd0, d); check("R8 strobe reads 0", d, 16'h0011);
    ticks(3);
    rd(2'd1, d); check("R8 prescaler restarted", d, 16'd20);
    ticks(1);
    rd(2'd1, d); check("R8 first terminal after 4", d, 16'd19);

    // R2 clearing enable returns count to 0x00FF
    wr(2'd0, 16'h0000);
    rd(2'd1, d); check("R2 disable resets count", d, 16'h00FF);

    // R10 control readback and unused address
    wr(2'd0, 16'h003B);
    rd(2'd0, d); check("R10 ctrl readback", d, 16'h0033);
    rd(2'd3, d); check("R10 addr3 reads 0", d, 16'h0000);

    summary();
  end
endmodule